// File: doc/BRIEF.md
# Hop-Count Spoof Filter with Learning

This block judges whether a packet's source address is forged. For each lookup it gets the 32-bit source address and the 8-bit TTL the packet arrived with. It works out the TTL the sender most likely started with, and from that the number of routers the packet crossed. It then compares that hop count with the one it has on record for the sender's /24 block.

The record is an associative key table. Each entry keys one /24 prefix and sits at the same index as a hop-count word in a parallel register array. An unknown prefix is written into the table along with its hop count, and that packet passes. Once every entry is taken, new prefixes replace old ones in rotation. A small allocation state machine has two states, `TBL_FILL` (free entries remain) and `TBL_FULL` (every entry is in use). It makes one transition, FILL→FULL, on the learn that takes the last free entry. FULL has no exit except reset.

The block takes one lookup per clock. Each verdict appears exactly one cycle after its lookup. Header parsing and packet storage are handled elsewhere.

Top module: `hop_spoof_filter`

## Requirements
- R1: After reset `out_valid` is low, the table holds no entries, and the state machine is in `TBL_FILL`.
- R2: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high. A new lookup is accepted every cycle.
- R3: A lookup with TTL 0 gives `out_pass` = 0 (drop) and writes nothing into the table.
- R4: The inferred initial TTL is the smallest member of {30, 32, 60, 64, 128, 255} that is greater than or equal to the arriving TTL.
- R5: The computed hop count is the inferred initial TTL minus the arriving TTL, 8 bits wide.
- R6: Only `in_src[31:8]` is compared against the table. `in_src[7:0]` has no effect on the verdict.
- R7: A lookup with nonzero TTL whose prefix is not in the table stores the prefix and its hop count, and gives `out_pass` = 1.
- R8: On a table hit, `out_pass` = 1 when the stored hop count equals the computed one and 0 otherwise. A hit never changes the table.
- R9: A learn made by one lookup is visible to the lookup in the very next cycle.
- R10: Learns fill entries 0, 1, 2, … in order. When the table is full, each further learn overwrites the entry after the last one written, wrapping from the last entry to entry 0. `TBL_FULL` is held until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Lookup strobe |
| in_src | input | 32 | Source address of the packet |
| in_ttl | input | 8 | TTL the packet arrived with |
| out_valid | output | 1 | Verdict strobe, one cycle after `in_valid` |
| out_pass | output | 1 | 1 = legitimate, 0 = spoofed or dropped |

## Verification
The bound checker checks the following on every cycle:
- the one-cycle verdict timing;
- the TTL-0 drop and the fact that it never learns;
- the pass on a miss, and the pass or drop on a hit, judged from the table's hit word against the separately computed hop count;
- the rotation of the write pointer;
- that the full state is held.

Only the bench's scenarios can show the rest, because each of these needs a history of earlier lookups:
- the initial-TTL band edges;
- that the low address byte is ignored;
- that a learn is seen by a back-to-back lookup;
- which prefix is evicted once the table has wrapped.

The bench does this by comparing every cycle against a behavioural model of the table.

// File: rtl/hcf_pkg.sv
`timescale 1ns/1ps
package hcf_pkg;
    localparam int TTL_W  = 8;
    localparam int N_INIT = 6;

    typedef logic [TTL_W-1:0] ttl_t;

    // Candidate sender TTLs, ascending (order matters for the "smallest fit" rule, R4)
    localparam ttl_t INIT_TTLS [N_INIT] = '{8'd30, 8'd32, 8'd60, 8'd64, 8'd128, 8'd255};

    typedef enum logic {
        TBL_FILL = 1'b0,
        TBL_FULL = 1'b1
    } tbl_state_e;
endpackage

// File: rtl/hcf_ttl_infer.sv
`timescale 1ns/1ps
module hcf_ttl_infer
    import hcf_pkg::*;
(
    input  ttl_t arr_ttl,
    output ttl_t hop_cnt,
    output logic ttl_zero
);
    logic [N_INIT-1:0] fits;
    ttl_t              init_ttl;

    for (genvar g = 0; g < N_INIT; g++) begin : g_fit
        assign fits[g] = (arr_ttl <= INIT_TTLS[g]);
    end

    // R4: scan from the top so the smallest fitting candidate wins
    always_comb begin
        init_ttl = INIT_TTLS[N_INIT-1];
        for (int i = N_INIT - 1; i >= 0; i--) begin
            if (fits[i]) begin
                init_ttl = INIT_TTLS[i];
            end
        end
    end

    // R5
    assign hop_cnt  = init_ttl - arr_ttl;
    assign ttl_zero = (arr_ttl == '0);
endmodule

// File: rtl/hcf_addr_table.sv
`timescale 1ns/1ps
module hcf_addr_table
    import hcf_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int KEY_W = 24,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] lk_key,
    output logic             lk_hit,
    output ttl_t             lk_hop,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_key,
    input  ttl_t             wr_hop
);
    logic [KEY_W-1:0] keys [DEPTH];
    ttl_t             hops [DEPTH];
    logic [DEPTH-1:0] vld;
    logic [DEPTH-1:0] match;
    logic [IDX_W-1:0] hit_idx;

    // Parallel key compare, one comparator per entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = vld[g] && (keys[g] == lk_key);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (wr_en) begin
            vld[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            keys[wr_idx] <= wr_key;
            hops[wr_idx] <= wr_hop;
        end
    end

    // Index of the matching entry; same index selects the hop word
    always_comb begin
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign lk_hit = |match;
    assign lk_hop = hops[hit_idx];
endmodule

// File: rtl/hcf_alloc_fsm.sv
`timescale 1ns/1ps
module hcf_alloc_fsm
    import hcf_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             learn,
    output logic [IDX_W-1:0] wr_ptr,
    output logic             tbl_full
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    tbl_state_e       state_q, state_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TBL_FILL;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        if (learn) begin
            ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
        unique case (state_q)
            TBL_FILL: if (learn && ptr_q == LAST) state_d = TBL_FULL;
            TBL_FULL: state_d = TBL_FULL;
            default:  state_d = TBL_FILL;
        endcase
    end

    always_comb begin
        wr_ptr   = ptr_q;
        tbl_full = (state_q == TBL_FULL);
    end
endmodule

// File: rtl/hop_spoof_filter.sv
`timescale 1ns/1ps
module hop_spoof_filter
    import hcf_pkg::*;
#(
    parameter int DEPTH    = 128,
    parameter int ADDR_W   = 32,
    parameter int PREFIX_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_src,
    input  logic [7:0]        in_ttl,
    output logic              out_valid,
    output logic              out_pass
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [PREFIX_W-1:0] lk_key;
    ttl_t                calc_hop;
    ttl_t                hit_hop;
    logic                ttl_zero;
    logic                hit;
    logic                learn;
    logic                pass_c;
    logic [IDX_W-1:0]    wr_ptr;
    logic                tbl_full;

    assign lk_key = in_src[ADDR_W-1 -: PREFIX_W];

    hcf_ttl_infer u_ttl (
        .arr_ttl  (in_ttl),
        .hop_cnt  (calc_hop),
        .ttl_zero (ttl_zero)
    );

    hcf_addr_table #(
        .DEPTH (DEPTH),
        .KEY_W (PREFIX_W),
        .IDX_W (IDX_W)
    ) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_key (lk_key),
        .lk_hit (hit),
        .lk_hop (hit_hop),
        .wr_en  (learn),
        .wr_idx (wr_ptr),
        .wr_key (lk_key),
        .wr_hop (calc_hop)
    );

    hcf_alloc_fsm #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_alloc (
        .clk      (clk),
        .rst_n    (rst_n),
        .learn    (learn),
        .wr_ptr   (wr_ptr),
        .tbl_full (tbl_full)
    );

    // Learn only a usable miss (R3, R7)
    assign learn  = in_valid && !ttl_zero && !hit;
    assign pass_c = !ttl_zero && (!hit || (hit_hop == calc_hop));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pass  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_pass  <= in_valid && pass_c;
        end
    end
endmodule

// File: rtl/hop_spoof_filter_chk.sv
`timescale 1ns/1ps
module hop_spoof_filter_chk #(
    parameter int DEPTH = 128,
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [31:0]      in_src,
    input logic [7:0]       in_ttl,
    input logic             out_valid,
    input logic             out_pass,
    input logic             hit,
    input logic [7:0]       hit_hop,
    input logic [7:0]       calc_hop,
    input logic             learn,
    input logic [IDX_W-1:0] wr_ptr,
    input logic             tbl_full
);
    a_r2_verdict_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r3_ttl_zero_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ttl == 8'd0) |=> !out_pass);
    a_r3_ttl_zero_no_learn: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ttl == 8'd0) |-> !learn);
    a_r7_miss_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ttl != 8'd0 && !hit) |=> out_pass);
    a_r8_mismatch_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hit && hit_hop != calc_hop) |=> !out_pass);
    a_r8_match_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ttl != 8'd0 && hit && hit_hop == calc_hop) |=> out_pass);
    a_r8_hit_no_learn: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !learn);
    a_r10_ptr_rotates: assert property (@(posedge clk) disable iff (!rst_n)
        learn |=> (wr_ptr == (($past(wr_ptr) == IDX_W'(DEPTH - 1)) ? '0 : $past(wr_ptr) + 1'b1)));
    a_r10_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !learn |=> $stable(wr_ptr));
    a_r10_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_full |=> tbl_full);
    a_r6_src_known: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !$isunknown(in_src));
endmodule

bind hop_spoof_filter hop_spoof_filter_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_src    (in_src),
    .in_ttl    (in_ttl),
    .out_valid (out_valid),
    .out_pass  (out_pass),
    .hit       (hit),
    .hit_hop   (hit_hop),
    .calc_hop  (calc_hop),
    .learn     (learn),
    .wr_ptr    (wr_ptr),
    .tbl_full  (tbl_full)
);

// File: tb/tb_hop_spoof_filter.sv
`timescale 1ns/1ps
module tb_hop_spoof_filter;
    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_src = '0;
    logic [7:0]  in_ttl = '0;
    logic        out_valid;
    logic        out_pass;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    hop_spoof_filter #(.DEPTH(D)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_src    (in_src),
        .in_ttl    (in_ttl),
        .out_valid (out_valid),
        .out_pass  (out_pass)
    );

    // Behavioural reference table
    int    m_key [D];
    int    m_hop [D];
    bit    m_vld [D];
    int    m_ptr = 0;
    bit    exp_v = 1'b0;
    bit    exp_p = 1'b0;
    string exp_tag = "R1";

    function automatic int infer_init(int ttl);
        int cands[6] = '{30, 32, 60, 64, 128, 255};
        foreach (cands[i]) if (cands[i] >= ttl) return cands[i];
        return 255;
    endfunction

    function automatic bit model(logic [31:0] src, int ttl);
        int key;
        int hop;
        key = int'(src >> 8);
        if (ttl == 0) return 1'b0;
        hop = infer_init(ttl) - ttl;
        for (int i = 0; i < D; i++) begin
            if (m_vld[i] && m_key[i] == key) return (m_hop[i] == hop);
        end
        m_key[m_ptr] = key;
        m_hop[m_ptr] = hop;
        m_vld[m_ptr] = 1'b1;
        m_ptr = (m_ptr + 1) % D;
        return 1'b1;
    endfunction

    task automatic compare();
        n_chk++;
        if (out_valid !== exp_v || (exp_v && out_pass !== exp_p)) begin
            n_bad++;
            $display("FAIL %s: valid/pass = %b/%b expected %b/%b at %0t",
                     exp_tag, out_valid, out_pass, exp_v, exp_p, $time);
        end
    endtask

    task automatic step(bit v, logic [31:0] src, int ttl, string tag);
        @(negedge clk);
        compare();
        in_valid = v;
        in_src   = src;
        in_ttl   = 8'(ttl);
        exp_v    = v;
        exp_p    = v ? model(src, ttl) : 1'b0;
        exp_tag  = tag;
    endtask

    function automatic logic [31:0] pfx(int n, int low);
        return {8'd10, 8'(n), 8'(n * 3 + 1), 8'(low)};
    endfunction

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        foreach (m_vld[i]) m_vld[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset, nothing valid
        step(0, '0, 0, "R1");
        step(0, '0, 0, "R1");
        // R1/R7: empty table, first sight passes and learns
        step(1, pfx(1, 5), 30, "R7");
        // R9: back-to-back, hop 0 vs hop 1 (ttl 31 -> init 32)
        step(1, pfx(1, 9), 31, "R9");
        // R4: ttl 32 -> init 32, hop 0 matches
        step(1, pfx(1, 200), 32, "R4");
        // R6: only low byte differs, still hits
        step(1, pfx(1, 77), 30, "R6");
        // R4/R5 band edges
        step(1, pfx(2, 0), 129, "R5");
        step(1, pfx(2, 1), 255, "R4");
        step(1, pfx(2, 2), 129, "R5");
        step(1, pfx(3, 0), 64, "R4");
        step(1, pfx(3, 0), 61, "R5");
        step(1, pfx(3, 0), 60, "R4");
        step(1, pfx(3, 0), 64, "R8");
        // R3: ttl zero dropped and not learned
        step(1, pfx(4, 0), 0, "R3");
        step(1, pfx(4, 0), 50, "R3");
        step(1, pfx(4, 0), 40, "R8");
        step(0, '0, 0, "R2");
        // R10: fill remaining entries, then wrap
        for (int n = 5; n < 12; n++) step(1, pfx(n, 0), 100 + n, "R10");
        step(1, pfx(1, 0), 20, "R10");
        step(1, pfx(2, 0), 20, "R10");
        step(1, pfx(11, 0), 1, "R10");
        step(1, pfx(5, 0), 3, "R10");
        // R2/R8: random mixed traffic with gaps
        for (int k = 0; k < 400; k++) begin
            int sel;
            sel = int'($urandom_range(0, 13));
            step(bit'($urandom_range(0, 3) != 0), pfx(sel, int'($urandom_range(0, 255))),
                 (sel % 3 == 0) ? int'($urandom_range(0, 255)) : 40 + sel, "R8");
        end
        step(0, '0, 0, "R2");
        step(0, '0, 0, "R2");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule